// File: doc/BRIEF.md
# Identification Page Command Decoder and Lock

This block sits behind a serial-memory bus front end and handles every command aimed at a 128-byte identification page that lives beside the main memory array. The front end turns the wire-level protocol into byte strobes, start and stop events and read-byte requests. This block turns them into acknowledge decisions, write strobes and read strobes for the page storage, and a one-time lock flag.

The device-type nibble of the select byte tells identification-page traffic apart from main-array traffic. One bit of the high address byte chooses between two kinds of command. The first kind writes page bytes. The second kind locks the page, or, when cut short, reports whether the page is locked. Once the page is locked it is read-only for good. The non-volatile lock cell is modelled as a register that can only be set; only `rst_n` clears it.

Every response is registered. The acknowledge for a byte appears on `ackStb`/`ackOk` in the clock cycle after its `byteStb`. Write and read strobes appear in that same following cycle, and the lock flag changes in the cycle after the stop event.

Top module: `idpg_lock`

## Requirements
- R1: After reset `locked` is 0, and `ackStb`, `idWrEn` and `idRdEn` are all 0.
- R2: Every `byteStb` gives exactly one `ackStb` pulse in the next cycle. After a start, the select byte is acknowledged (`ackOk`=1) only when bits 7:4 are 1011 and bits 3:1 equal `chipSel`. Any other select byte, or any byte sent before a start, gets `ackOk`=0, and the bytes that follow are refused until the next start.
- R3: After a matching select byte with bit 0 = 0, two address bytes are acknowledged. Bit 2 of the first address byte picks the lock/status command (1) or the page write (0); its other bits have no effect. Bits 6:0 of the second byte load the page pointer.
- R4: In a page write on an unlocked page with `wpIn` low, each data byte is acknowledged and gives one `idWrEn` pulse with `idWrAddr` equal to the pointer and `idWrData` equal to the byte. The pointer then steps by one, modulo 128.
- R5: In a page write while the page is locked, or while `wpIn` is high, data bytes get `ackOk`=0 and give no `idWrEn`.
- R6: A matching select byte with bit 0 = 1 is acknowledged. Each later `rdNext` gives one `idRdEn` pulse at the pointer, then the pointer steps by one, modulo 128, continuing from the last address load, write or read. Reads work whether or not the page is locked.
- R7: The first data byte of a lock/status command is acknowledged when the page is unlocked and refused when it is locked.
- R8: `locked` becomes 1 at a stop event only when it ends a lock/status command whose single acknowledged data byte had bit 1 = 1, and only when `wpIn` is low at that stop. A data byte with bit 1 = 0 leaves `locked` unchanged.
- R9: A start event after the data byte of a lock/status command abandons that command, so a stop that comes later does not change `locked`.
- R10: Once set, `locked` stays 1 through all later bus traffic, including further lock commands.
- R11: A second data byte in a lock/status command is refused and cancels the pending lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also clears the modelled lock cell |
| chipSel | input | 3 | Chip-select strap value compared with select-byte bits 3:1 |
| wpIn | input | 1 | Write protect; high blocks page writes and locking |
| startEvt | input | 1 | Start or repeated-start event, one cycle |
| stopEvt | input | 1 | Stop event, one cycle |
| byteStb | input | 1 | A byte from the controller is complete |
| byteVal | input | 8 | Value of that byte |
| rdNext | input | 1 | Bus front end asks for the next read byte |
| ackStb | output | 1 | Acknowledge decision valid |
| ackOk | output | 1 | 1 = acknowledge, 0 = refuse |
| idWrEn | output | 1 | Write strobe to page storage |
| idWrAddr | output | 7 | Page offset of the write |
| idWrData | output | 8 | Byte to write |
| idRdEn | output | 1 | Read strobe to page storage |
| idRdAddr | output | 7 | Page offset of the read |
| locked | output | 1 | Page lock flag |

## Verification
The bench writes across the top of the page and reads more than a full page, so both runs pass offset 127. A pointer that carried into bit 7 or stuck at the page end would show up as wrong addresses there. Each way a lock can fail to happen is tried before the real lock: data bit 1 clear, write protect high at the stop, an extra data byte, and a repeated start before the stop. A decoder that armed the lock too early, or forgot to disarm it, would lock the page in one of these cases and fail every later check. After the lock, the bench confirms that status queries and page writes are refused and that reads still work. A design whose write strobe ignored the lock would show an `idWrEn` pulse on a byte it had refused.

// File: rtl/idpg_pkg.sv
package idpg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_DATA, ST_READ, ST_SKIP
  } idpgState_e;

  typedef struct packed {
    logic ldPtr;
    logic wrStb;
    logic rdStb;
    logic setLock;
  } idpgStb_t;
endpackage

// File: rtl/idpg_ctrl.sv
module idpg_ctrl
  import idpg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [3:0] TYPE_ID = 4'b1011,
  parameter int LOCK_SEL_BIT = 2,
  parameter int LOCK_DATA_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        chipSel,
  input  logic              wpIn,
  input  logic              startEvt,
  input  logic              stopEvt,
  input  logic              byteStb,
  input  logic [DATA_W-1:0] byteVal,
  input  logic              rdNext,
  input  logic              lockedIn,
  output logic              ackStb,
  output logic              ackOk,
  output idpgStb_t          stb
);
  idpgState_e st, stNext;
  logic modeLock, modeNext;
  logic armed, armNext;
  logic firstData, firstNext;
  logic ackStbNext, ackOkNext;
  logic devHit;

  assign devHit = (byteVal[DATA_W-1 -: 4] == TYPE_ID) && (byteVal[3:1] == chipSel);

  always_comb begin
    stNext     = st;
    modeNext   = modeLock;
    armNext    = armed;
    firstNext  = firstData;
    ackStbNext = 1'b0;
    ackOkNext  = 1'b0;
    stb        = '0;
    if (startEvt) begin
      stNext  = ST_DEV;
      armNext = 1'b0;
    end else if (stopEvt) begin
      // lock commits only on a clean stop with protection released
      stb.setLock = (st == ST_DATA) && modeLock && armed && !wpIn;
      stNext      = ST_IDLE;
      armNext     = 1'b0;
    end else if (byteStb) begin
      ackStbNext = 1'b1;
      case (st)
        ST_DEV: begin
          if (devHit) begin
            ackOkNext = 1'b1;
            stNext    = byteVal[0] ? ST_READ : ST_AHI;
          end else begin
            stNext = ST_SKIP;
          end
        end
        ST_AHI: begin
          ackOkNext = 1'b1;
          modeNext  = byteVal[LOCK_SEL_BIT];
          stNext    = ST_ALO;
        end
        ST_ALO: begin
          ackOkNext = 1'b1;
          stb.ldPtr = 1'b1;
          firstNext = 1'b1;
          stNext    = ST_DATA;
        end
        ST_DATA: begin
          firstNext = 1'b0;
          if (modeLock) begin
            if (firstData && !lockedIn) begin
              ackOkNext = 1'b1;
              armNext   = byteVal[LOCK_DATA_BIT];
            end else begin
              armNext = 1'b0;
              stNext  = ST_SKIP;
            end
          end else if (!lockedIn && !wpIn) begin
            ackOkNext = 1'b1;
            stb.wrStb = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (rdNext && (st == ST_READ)) begin
      stb.rdStb = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      modeLock  <= 1'b0;
      armed     <= 1'b0;
      firstData <= 1'b0;
      ackStb    <= 1'b0;
      ackOk     <= 1'b0;
    end else begin
      st        <= stNext;
      modeLock  <= modeNext;
      armed     <= armNext;
      firstData <= firstNext;
      ackStb    <= ackStbNext;
      ackOk     <= ackOkNext;
    end
  end
endmodule

// File: rtl/idpg_dp.sv
module idpg_dp
  import idpg_pkg::*;
#(
  parameter int PAGE_AW = 7,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  idpgStb_t           stb,
  input  logic [DATA_W-1:0]  byteVal,
  output logic               idWrEn,
  output logic [PAGE_AW-1:0] idWrAddr,
  output logic [DATA_W-1:0]  idWrData,
  output logic               idRdEn,
  output logic [PAGE_AW-1:0] idRdAddr,
  output logic               locked
);
  localparam logic [PAGE_AW-1:0] PTR_ONE = PAGE_AW'(1);

  logic [PAGE_AW-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      idWrEn   <= 1'b0;
      idWrAddr <= '0;
      idWrData <= '0;
      idRdEn   <= 1'b0;
      idRdAddr <= '0;
      locked   <= 1'b0;
    end else begin
      idWrEn <= stb.wrStb;
      idRdEn <= stb.rdStb;
      if (stb.ldPtr) ptr <= byteVal[PAGE_AW-1:0];
      else if (stb.wrStb || stb.rdStb) ptr <= ptr + PTR_ONE; // wraps inside page
      if (stb.wrStb) begin
        idWrAddr <= ptr;
        idWrData <= byteVal;
      end
      if (stb.rdStb) idRdAddr <= ptr;
      if (stb.setLock) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/idpg_lock.sv
module idpg_lock
  import idpg_pkg::*;
#(
  parameter int PAGE_AW = 7,
  parameter int DATA_W = 8,
  parameter logic [3:0] TYPE_ID = 4'b1011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         chipSel,
  input  logic               wpIn,
  input  logic               startEvt,
  input  logic               stopEvt,
  input  logic               byteStb,
  input  logic [DATA_W-1:0]  byteVal,
  input  logic               rdNext,
  output logic               ackStb,
  output logic               ackOk,
  output logic               idWrEn,
  output logic [PAGE_AW-1:0] idWrAddr,
  output logic [DATA_W-1:0]  idWrData,
  output logic               idRdEn,
  output logic [PAGE_AW-1:0] idRdAddr,
  output logic               locked
);
  idpgStb_t stb;

  idpg_ctrl #(.DATA_W(DATA_W), .TYPE_ID(TYPE_ID)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chipSel(chipSel), .wpIn(wpIn),
    .startEvt(startEvt), .stopEvt(stopEvt), .byteStb(byteStb),
    .byteVal(byteVal), .rdNext(rdNext), .lockedIn(locked),
    .ackStb(ackStb), .ackOk(ackOk), .stb(stb)
  );

  idpg_dp #(.PAGE_AW(PAGE_AW), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .byteVal(byteVal),
    .idWrEn(idWrEn), .idWrAddr(idWrAddr), .idWrData(idWrData),
    .idRdEn(idRdEn), .idRdAddr(idRdAddr), .locked(locked)
  );
endmodule

// File: rtl/idpg_lock_chk.sv
module idpg_lock_chk (
  input logic clk,
  input logic rst_n,
  input logic wpIn,
  input logic stopEvt,
  input logic byteStb,
  input logic rdNext,
  input logic ackStb,
  input logic ackOk,
  input logic idWrEn,
  input logic idRdEn,
  input logic locked
);
  AST_WR_ONLY_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    idWrEn |-> !locked); // R5
  AST_WR_IS_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    idWrEn |-> (ackStb && ackOk)); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R10
  AST_LOCK_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(stopEvt)); // R8
  AST_LOCK_WP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> !$past(wpIn)); // R8
  AST_RD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    idRdEn |-> $past(rdNext)); // R6
  AST_ACK_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ackStb |-> $past(byteStb)); // R2
endmodule

bind idpg_lock idpg_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wpIn(wpIn), .stopEvt(stopEvt),
  .byteStb(byteStb), .rdNext(rdNext), .ackStb(ackStb), .ackOk(ackOk),
  .idWrEn(idWrEn), .idRdEn(idRdEn), .locked(locked)
);

// File: tb/idpg_lock_bench.sv
`timescale 1ns/1ps
module idpg_lock_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] chipSel = 3'b101;
  logic wpIn = 1'b0;
  logic startEvt = 1'b0, stopEvt = 1'b0, byteStb = 1'b0, rdNext = 1'b0;
  logic [7:0] byteVal = 8'h00;
  logic ackStb, ackOk, idWrEn, idRdEn, locked;
  logic [6:0] idWrAddr, idRdAddr;
  logic [7:0] idWrData;
  int nChk = 0, nFail = 0;
  logic done = 1'b0;

  localparam logic [7:0] DEV_W = 8'hBA; // 1011 101 0
  localparam logic [7:0] DEV_R = 8'hBB;

  always #4 clk = ~clk;

  idpg_lock u_idpg_lock (
    .clk(clk), .rst_n(rst_n), .chipSel(chipSel), .wpIn(wpIn),
    .startEvt(startEvt), .stopEvt(stopEvt), .byteStb(byteStb),
    .byteVal(byteVal), .rdNext(rdNext), .ackStb(ackStb), .ackOk(ackOk),
    .idWrEn(idWrEn), .idWrAddr(idWrAddr), .idWrData(idWrData),
    .idRdEn(idRdEn), .idRdAddr(idRdAddr), .locked(locked)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic startPulse();
    @(negedge clk) startEvt = 1'b1;
    @(negedge clk) startEvt = 1'b0;
  endtask

  task automatic stopPulse();
    @(negedge clk) stopEvt = 1'b1;
    @(negedge clk) stopEvt = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expOk, input logic expWr,
                          input logic [6:0] expAddr, input string tag);
    @(negedge clk) begin byteStb = 1'b1; byteVal = b; end
    @(negedge clk) byteStb = 1'b0;
    chk(ackStb === 1'b1, {tag, " ackStb"}, ackStb, 1);
    chk(ackOk === expOk, {tag, " ackOk"}, ackOk, expOk);
    chk(idWrEn === expWr, {tag, " idWrEn"}, idWrEn, expWr);
    if (expWr) begin
      chk(idWrAddr === expAddr, {tag, " idWrAddr"}, idWrAddr, expAddr);
      chk(idWrData === b, {tag, " idWrData"}, idWrData, b);
    end
  endtask

  task automatic readByte(input logic [6:0] expAddr, input string tag);
    @(negedge clk) rdNext = 1'b1;
    @(negedge clk) rdNext = 1'b0;
    chk(idRdEn === 1'b1, {tag, " idRdEn"}, idRdEn, 1);
    chk(idRdAddr === expAddr, {tag, " idRdAddr"}, idRdAddr, expAddr);
  endtask

  // header of a write-direction command: select + two address bytes
  task automatic header(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    startPulse();
    sendByte(DEV_W, 1'b1, 1'b0, 7'd0, tag);
    sendByte(hi, 1'b1, 1'b0, 7'd0, tag);
    sendByte(lo, 1'b1, 1'b0, 7'd0, tag);
  endtask

  task automatic checkLock(input logic exp, input string tag);
    chk(locked === exp, {tag, " locked"}, locked, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkLock(1'b0, "R1");
    chk(ackStb === 1'b0 && idWrEn === 1'b0 && idRdEn === 1'b0, "R1 strobes",
        {ackStb, idWrEn, idRdEn}, 0);

    // R2: byte before any start, main-array type, wrong chip select
    sendByte(DEV_W, 1'b0, 1'b0, 7'd0, "R2 idle");
    startPulse();
    sendByte(8'hAA, 1'b0, 1'b0, 7'd0, "R2 main type");
    sendByte(8'h00, 1'b0, 1'b0, 7'd0, "R2 skip");
    sendByte(8'h55, 1'b0, 1'b0, 7'd0, "R2 skip");
    stopPulse();
    for (int c = 0; c < 8; c++) begin
      startPulse();
      sendByte({4'b1011, 3'(c), 1'b0}, (c == 5), 1'b0, 7'd0, "R2 chipSel sweep");
      stopPulse();
    end

    // R3 R4: write crossing the page end; high byte noise bits set, bit 2 clear
    header(8'hFB, 8'hF8, "R3");
    for (int i = 0; i < 16; i++)
      sendByte(8'(i) ^ 8'h5A, 1'b1, 1'b1, 7'((120 + i) % 128), "R4 wrap");
    stopPulse();
    checkLock(1'b0, "R4");

    // R6: random read from 3, over a full page and beyond
    header(8'h00, 8'h83, "R3 ptr");
    startPulse();
    sendByte(DEV_R, 1'b1, 1'b0, 7'd0, "R6 sel");
    for (int i = 0; i < 130; i++) readByte(7'((3 + i) % 128), "R6 seq");
    stopPulse();
    startPulse();
    sendByte(DEV_R, 1'b1, 1'b0, 7'd0, "R6 cur sel");
    readByte(7'd5, "R6 current");
    stopPulse();

    // R5: write with protect high
    wpIn = 1'b1;
    header(8'h00, 8'h10, "R5 wp");
    sendByte(8'h77, 1'b0, 1'b0, 7'd0, "R5 wp data");
    stopPulse();
    wpIn = 1'b0;

    // R7 R9: status query cut short by a start
    header(8'h04, 8'h00, "R7");
    sendByte(8'h02, 1'b1, 1'b0, 7'd0, "R7 unlocked");
    startPulse();
    stopPulse();
    checkLock(1'b0, "R9 abort");

    // R8: data bit 1 clear
    header(8'h04, 8'h00, "R8");
    sendByte(8'hFD, 1'b1, 1'b0, 7'd0, "R8 bit1 clear");
    stopPulse();
    checkLock(1'b0, "R8 bit1 clear");

    // R8: protect high at the stop
    header(8'h04, 8'h00, "R8");
    sendByte(8'h02, 1'b1, 1'b0, 7'd0, "R8 wp");
    wpIn = 1'b1;
    stopPulse();
    wpIn = 1'b0;
    checkLock(1'b0, "R8 wp high");

    // R11: extra data byte
    header(8'h04, 8'h00, "R11");
    sendByte(8'h02, 1'b1, 1'b0, 7'd0, "R11 first");
    sendByte(8'h02, 1'b0, 1'b0, 7'd0, "R11 second");
    stopPulse();
    checkLock(1'b0, "R11");

    // R8: real lock
    header(8'hFF, 8'h00, "R8");
    sendByte(8'h02, 1'b1, 1'b0, 7'd0, "R8 lock");
    stopPulse();
    checkLock(1'b1, "R8 lock");

    // R7: status now refused
    header(8'h04, 8'h00, "R7");
    sendByte(8'h00, 1'b0, 1'b0, 7'd0, "R7 locked");
    startPulse();
    stopPulse();

    // R5: write refused once locked
    header(8'h00, 8'h20, "R5 lk");
    sendByte(8'h11, 1'b0, 1'b0, 7'd0, "R5 locked data");
    sendByte(8'h22, 1'b0, 1'b0, 7'd0, "R5 locked data");
    stopPulse();

    // R6 R10: reads still served, lock survives further commands
    startPulse();
    sendByte(DEV_R, 1'b1, 1'b0, 7'd0, "R6 locked sel");
    readByte(7'd32, "R6 locked read");
    stopPulse();
    header(8'h04, 8'h00, "R10");
    sendByte(8'h00, 1'b0, 1'b0, 7'd0, "R10 relock");
    stopPulse();
    checkLock(1'b1, "R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule